// File: doc/BRIEF.md
# Clock Generator Mode Controller

This block decides where the system clock of an on-chip clock generator comes from and whether the frequency-locked loop is closed. It holds a two-bit clock-select code written through a strobe. From that code, the DCO-stable flag, the external-reference status and stop-mode events, it steps through five states:

- **OFF**: entered on stop entry.
- **SELF**: self-clocked, with the loop open. This is the default state.
- **LOOP_INT**: loop engaged on the internal reference.
- **BYPASS_EXT**: loop bypassed, running directly on the external clock.
- **LOOP_EXT**: loop engaged on the external reference.

The controller drives four outputs: the current mode, an enable for the generated clock, an engage signal for the external clock, and the write enable of the frequency-filter register.

The transitions are named as follows:

- **stop-in**: any running state to OFF.
- **wake-irq**: OFF to BYPASS_EXT or SELF.
- **wake-rst**: OFF to SELF, with the code cleared.
- **close-loop**: SELF to LOOP_INT or LOOP_EXT once the DCO is stable.
- **select**: a running state to the mode chosen by the code.
- **fallback**: any external mode to SELF when the reference is lost.

A crystal qualifier counts crystal-clock ticks. The external clock is engaged only after the count completes. The count restarts on a loss-of-clock pulse or on any stop exit. The analog DCO, the loop arithmetic and the dividers sit outside and appear only as status inputs. All flags are sampled on the controller clock.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: After reset the mode output is SELF and the stored code is 00. The mode encoding is 0 OFF, 1 SELF, 2 LOOP_INT, 3 BYPASS_EXT, 4 LOOP_EXT. The code mapping is 00 SELF, 01 LOOP_INT, 10 BYPASS_EXT, 11 LOOP_EXT. In SELF, clock enable is 1 and external engage is 0.
- R2: A stop-entry pulse in any running state puts the controller in OFF at the next edge, where the clock enable is 0. Stop entry wins over every other transition in that cycle.
- R3: An interrupt-caused stop exit from OFF goes to BYPASS_EXT when the stored code is 10, and to SELF for any other code.
- R4: In SELF with code 01 or 11, the controller stays in SELF while DCO-stable is low. It moves to LOOP_INT (code 01) or LOOP_EXT (code 11) at the first edge where DCO-stable is high.
- R5: Code 00 returns every running state to SELF.
- R6: With code 10 or 11, the external reference counts as lost when external-detected is low and loss-of-clock is high. A lost reference sends the controller to SELF, overriding the code.
- R7: The filter write enable follows the write request only in SELF and is 0 in every other mode.
- R8: A reset-caused stop exit from OFF clears the stored code to 00 and resumes in SELF, whatever the code was before. The controller then stays in SELF.
- R9: External engage is 1 only in BYPASS_EXT or LOOP_EXT, and only after QUAL_TICKS crystal ticks (4096 by default) have been counted. In BYPASS_EXT the clock enable stays 0 until the count completes. In LOOP_EXT the clock enable is 1 throughout.
- R10: A loss-of-clock pulse or any stop exit restarts the crystal count from zero.
- R11: Code 10 in a running state with the reference present selects BYPASS_EXT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we_i | input | 1 | Strobe that writes the clock-select code |
| sel_wdata_i | input | 2 | Clock-select code to write |
| dco_stable_i | input | 1 | DCO output is stable |
| ext_det_i | input | 1 | External reference detected |
| loc_i | input | 1 | Loss-of-clock flag |
| stop_enter_i | input | 1 | Stop-mode entry event |
| stop_exit_i | input | 1 | Stop-mode exit event |
| stop_exit_rst_i | input | 1 | Exit cause: 1 reset, 0 interrupt |
| xtal_tick_i | input | 1 | One crystal-clock tick |
| flt_req_i | input | 1 | Request to write the filter register |
| mode_o | output | 3 | Current mode |
| clk_out_en_o | output | 1 | Generated clock enable |
| ext_engage_o | output | 1 | Engage the external clock |
| flt_wr_en_o | output | 1 | Filter register write enable |

## Verification
Two functions can land on the same edge: the fallback on a lost reference and the stop-in transition. The bench provokes this by entering BYPASS_EXT and then raising loss-of-clock, dropping external-detected and pulsing stop entry in one cycle. It judges the result by requiring OFF with the clock enable low, not SELF. A second overlap is a code write in the same cycle as reference loss. The bench sweeps every starting mode against every new code with the reference present and lost, and requires the mode that the fallback and select rules together predict.

// File: rtl/clkgen_pkg.sv
`timescale 1ns/1ps
package clkgen_pkg;
    typedef enum logic [2:0] {
        MODE_OFF        = 3'd0,
        MODE_SELF       = 3'd1,
        MODE_LOOP_INT   = 3'd2,
        MODE_BYPASS_EXT = 3'd3,
        MODE_LOOP_EXT   = 3'd4
    } cg_mode_e;

    localparam logic [1:0] SEL_SELF   = 2'b00;
    localparam logic [1:0] SEL_LOOPI  = 2'b01;
    localparam logic [1:0] SEL_BYPASS = 2'b10;
    localparam logic [1:0] SEL_LOOPE  = 2'b11;
endpackage

// File: rtl/clkgen_xtal_qual.sv
`timescale 1ns/1ps
module clkgen_xtal_qual #(
    parameter int QUAL_TICKS = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int CW = $clog2(QUAL_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(QUAL_TICKS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= '0;
        else if (tick_i && cnt_q != LIMIT)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = (cnt_q == LIMIT);

    // R10
    qual_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

    // R9
    qual_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clr_i) |=> done_o);
endmodule

// File: rtl/clkgen_mode_fsm.sv
`timescale 1ns/1ps
module clkgen_mode_fsm
    import clkgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_we_i,
    input  logic [1:0] sel_wdata_i,
    input  logic       dco_stable_i,
    input  logic       ext_det_i,
    input  logic       loc_i,
    input  logic       stop_enter_i,
    input  logic       stop_exit_i,
    input  logic       stop_exit_rst_i,
    input  logic       qual_done_i,
    input  logic       flt_req_i,
    output cg_mode_e   mode_o,
    output logic       clk_out_en_o,
    output logic       ext_engage_o,
    output logic       flt_wr_en_o
);
    cg_mode_e   state_q, state_d, run_tgt;
    logic [1:0] sel_q;
    logic       ref_lost;
    logic       wake_rst;

    assign ref_lost = !ext_det_i && loc_i;
    assign wake_rst = (state_q == MODE_OFF) && stop_exit_i && stop_exit_rst_i;

    // stored select code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sel_q <= SEL_SELF;
        else if (wake_rst)
            sel_q <= SEL_SELF;
        else if (sel_we_i)
            sel_q <= sel_wdata_i;
    end

    // target of the select / close-loop / fallback rules
    always_comb begin
        if (sel_q == SEL_SELF)
            run_tgt = MODE_SELF;
        else if (sel_q[1] && ref_lost)
            run_tgt = MODE_SELF;
        else if (sel_q == SEL_BYPASS)
            run_tgt = MODE_BYPASS_EXT;
        else if (state_q == MODE_SELF && !dco_stable_i)
            run_tgt = MODE_SELF;
        else if (sel_q == SEL_LOOPI)
            run_tgt = MODE_LOOP_INT;
        else
            run_tgt = MODE_LOOP_EXT;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_OFF: begin
                if (stop_exit_i) begin
                    if (stop_exit_rst_i)
                        state_d = MODE_SELF;
                    else if (sel_q == SEL_BYPASS)
                        state_d = MODE_BYPASS_EXT;
                    else
                        state_d = MODE_SELF;
                end
            end
            MODE_SELF, MODE_LOOP_INT, MODE_BYPASS_EXT, MODE_LOOP_EXT: begin
                if (stop_enter_i)
                    state_d = MODE_OFF;
                else
                    state_d = run_tgt;
            end
            default: state_d = MODE_SELF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= MODE_SELF;
        else
            state_q <= state_d;
    end

    // output decode
    always_comb begin
        mode_o       = state_q;
        clk_out_en_o = 1'b1;
        ext_engage_o = 1'b0;
        flt_wr_en_o  = 1'b0;
        unique case (state_q)
            MODE_OFF:        clk_out_en_o = 1'b0;
            MODE_SELF:       flt_wr_en_o  = flt_req_i;
            MODE_LOOP_INT:   ;
            MODE_BYPASS_EXT: begin
                clk_out_en_o = qual_done_i;
                ext_engage_o = qual_done_i;
            end
            MODE_LOOP_EXT:   ext_engage_o = qual_done_i;
            default:         clk_out_en_o = 1'b0;
        endcase
    end

    // R2
    stop_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != MODE_OFF && stop_enter_i) |=> (state_q == MODE_OFF));

    // R8
    wake_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_rst |=> (state_q == MODE_SELF && sel_q == SEL_SELF));

    // R4
    dco_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_SELF && !dco_stable_i)
            |=> (state_q != MODE_LOOP_INT && state_q != MODE_LOOP_EXT));

    // R6
    fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == MODE_BYPASS_EXT || state_q == MODE_LOOP_EXT)
            && ref_lost && !stop_enter_i) |=> (state_q == MODE_SELF));
endmodule

// File: rtl/clkgen_mode_ctrl.sv
`timescale 1ns/1ps
module clkgen_mode_ctrl
    import clkgen_pkg::*;
#(
    parameter int QUAL_TICKS = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_we_i,
    input  logic [1:0] sel_wdata_i,
    input  logic       dco_stable_i,
    input  logic       ext_det_i,
    input  logic       loc_i,
    input  logic       stop_enter_i,
    input  logic       stop_exit_i,
    input  logic       stop_exit_rst_i,
    input  logic       xtal_tick_i,
    input  logic       flt_req_i,
    output logic [2:0] mode_o,
    output logic       clk_out_en_o,
    output logic       ext_engage_o,
    output logic       flt_wr_en_o
);
    logic     qual_done;
    cg_mode_e mode_e;

    clkgen_xtal_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (loc_i || stop_exit_i),
        .tick_i (xtal_tick_i),
        .done_o (qual_done)
    );

    clkgen_mode_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .sel_we_i        (sel_we_i),
        .sel_wdata_i     (sel_wdata_i),
        .dco_stable_i    (dco_stable_i),
        .ext_det_i       (ext_det_i),
        .loc_i           (loc_i),
        .stop_enter_i    (stop_enter_i),
        .stop_exit_i     (stop_exit_i),
        .stop_exit_rst_i (stop_exit_rst_i),
        .qual_done_i     (qual_done),
        .flt_req_i       (flt_req_i),
        .mode_o          (mode_e),
        .clk_out_en_o    (clk_out_en_o),
        .ext_engage_o    (ext_engage_o),
        .flt_wr_en_o     (flt_wr_en_o)
    );

    assign mode_o = mode_e;

    // R9
    engage_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_engage_o |-> qual_done);

    // R9
    bypass_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_BYPASS_EXT && !qual_done) |-> !clk_out_en_o);

    // R7
    flt_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_wr_en_o |-> (mode_e == MODE_SELF));
endmodule

// File: tb/clkgen_mode_ctrl_tb.sv
`timescale 1ns/1ps
module clkgen_mode_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_we = 1'b0;
    logic [1:0] sel_wdata = 2'b00;
    logic       dco = 1'b0, ext_det = 1'b1, loc = 1'b0;
    logic       s_in = 1'b0, s_out = 1'b0, s_rst = 1'b0;
    logic       tick = 1'b0, flt_req = 1'b0;
    logic [2:0] mode;
    logic       clk_en, engage, flt_en;
    int         checks = 0, errors = 0;

    always #4 clk = ~clk;

    clkgen_mode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sel_we_i(sel_we), .sel_wdata_i(sel_wdata),
        .dco_stable_i(dco), .ext_det_i(ext_det), .loc_i(loc),
        .stop_enter_i(s_in), .stop_exit_i(s_out), .stop_exit_rst_i(s_rst),
        .xtal_tick_i(tick), .flt_req_i(flt_req),
        .mode_o(mode), .clk_out_en_o(clk_en), .ext_engage_o(engage),
        .flt_wr_en_o(flt_en)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sel_we = 1'b0; dco = 1'b0; ext_det = 1'b1; loc = 1'b0;
        s_in = 1'b0; s_out = 1'b0; s_rst = 1'b0; tick = 1'b0; flt_req = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic write_sel(input logic [1:0] code);
        sel_we = 1'b1; sel_wdata = code;
        step(1);
        sel_we = 1'b0;
    endtask

    task automatic pulse_stop_in();
        s_in = 1'b1; step(1); s_in = 1'b0;
    endtask

    task automatic pulse_stop_out(input logic cause_rst);
        s_out = 1'b1; s_rst = cause_rst; step(1); s_out = 1'b0; s_rst = 1'b0;
    endtask

    // expected mode after writing code s with reference lost/present, DCO stable
    function automatic int exp_sweep(input int s, input bit lost);
        if (s == 0) return 1;              // R5
        if (s >= 2 && lost) return 1;      // R6
        if (s == 2) return 3;              // R11
        return (s == 1) ? 2 : 4;           // R4
    endfunction

    initial begin
        #1200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 mode", mode, 1);
        chk("R1 clk_en", clk_en, 1);
        chk("R1 engage", engage, 0);
        flt_req = 1'b1; #1;
        chk("R7 flt in SELF", flt_en, 1);
        flt_req = 1'b0;

        // R5 R6 R11 R4 R7: sweep start mode x new code x reference state
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int l = 0; l < 2; l++) begin
                    do_reset();
                    dco = 1'b1;
                    write_sel(2'(m));
                    step(1);
                    chk("R4 R11 start", mode, m + 1);
                    ext_det = (l == 0); loc = (l == 1);
                    write_sel(2'(s));
                    step(1);
                    chk(l ? "R6 R5 sweep lost" : "R5 R11 sweep ok",
                        mode, exp_sweep(s, l[0]));
                    flt_req = 1'b1; #1;
                    chk("R7 flt gate", flt_en, (mode == 3'd1) ? 1 : 0);
                    flt_req = 1'b0;
                end
            end
        end

        // R2 R3 R4: stop and interrupt wake for each code
        for (int s = 0; s < 4; s++) begin
            do_reset();
            write_sel(2'(s));
            step(1);
            pulse_stop_in();
            chk("R2 off", mode, 0);
            chk("R2 clk_en off", clk_en, 0);
            flt_req = 1'b1; #1;
            chk("R7 flt in OFF", flt_en, 0);
            flt_req = 1'b0;
            pulse_stop_out(1'b0);
            chk("R3 wake irq", mode, (s == 2) ? 3 : 1);
            step(3);
            chk("R4 hold without dco", mode, (s == 2) ? 3 : 1);
            dco = 1'b1;
            step(1);
            chk("R4 close loop", mode, (s == 0) ? 1 : (s == 1) ? 2 : (s == 2) ? 3 : 4);
        end

        // R8: reset-caused wake for each code
        for (int s = 0; s < 4; s++) begin
            do_reset();
            dco = 1'b1;
            write_sel(2'(s));
            step(1);
            pulse_stop_in();
            pulse_stop_out(1'b1);
            chk("R8 wake rst", mode, 1);
            step(3);
            chk("R8 code cleared", mode, 1);
        end

        // R2 precedence over fallback in the same cycle
        do_reset();
        write_sel(2'b10);
        step(1);
        s_in = 1'b1; ext_det = 1'b0; loc = 1'b1;
        step(1);
        s_in = 1'b0; ext_det = 1'b1; loc = 1'b0;
        chk("R2 stop beats fallback", mode, 0);
        chk("R2 clk_en", clk_en, 0);

        // R9 R10: crystal qualification in BYPASS_EXT
        do_reset();
        write_sel(2'b10);
        step(1);
        chk("R11 bypass", mode, 3);
        chk("R9 bypass clk_en before count", clk_en, 0);
        tick = 1'b1; step(4095); tick = 1'b0;
        chk("R9 engage at 4095", engage, 0);
        chk("R9 clk_en at 4095", clk_en, 0);
        tick = 1'b1; step(1); tick = 1'b0;
        chk("R9 engage at 4096", engage, 1);
        chk("R9 clk_en at 4096", clk_en, 1);
        loc = 1'b1; step(1); loc = 1'b0;
        chk("R10 loc restarts count", engage, 0);
        chk("R10 clk_en after loc", clk_en, 0);
        tick = 1'b1; step(4096); tick = 1'b0;
        chk("R9 requalified", engage, 1);
        pulse_stop_in();
        pulse_stop_out(1'b0);
        chk("R3 wake to bypass", mode, 3);
        chk("R10 stop exit restarts count", clk_en, 0);

        // R9 LOOP_EXT: internal clock runs while unqualified
        do_reset();
        dco = 1'b1;
        write_sel(2'b11);
        step(1);
        chk("R4 loop ext", mode, 4);
        chk("R9 loop ext clk_en", clk_en, 1);
        chk("R9 loop ext engage", engage, 0);
        tick = 1'b1; step(4096); tick = 1'b0;
        chk("R9 loop ext engaged", engage, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule